// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-clock static memory with a shared bidirectional data bus that carries reads and writes back to back, with no idle cycle when the bus changes direction. A read returns its data one full cycle after its address is taken. A write takes its data two cycles after its address. Both therefore use the same bus slot, two cycles after the command, and any mix of reads and writes can be issued on every cycle. The data bus has four 9-bit byte lanes, and each lane can be masked on a write. The memory depth is a parameter and can be kept small for simulation.

A command is taken at a rising edge. The host can continue an access as a four-beat burst, with the next addresses generated inside the block in either linear or XOR order. The host can freeze the whole block with a stall input. The read data drivers are controlled by an asynchronous output enable.

A low-power sleep request is handled by a four-state machine. The states are RUN, DOZE, SLEEP and RISE. The transitions are:
- RUN to DOZE when the request is sampled high.
- DOZE to SLEEP when it is high again, or DOZE back to RUN when it is low.
- SLEEP to RISE when it is sampled low.
- RISE to RUN when it is low again, or RISE back to SLEEP when it is high.

The block counts as asleep in SLEEP and in RISE. While asleep it ignores new commands, and the array keeps its contents.

Top module: `nobubble_sram`

## Requirements
- R1: A new access starts at an edge only if `stall` is low, `burst_cont` is low, `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. The access is a read if `wr_n` is high and a write if `wr_n` is low. With `burst_cont` low and any select inactive, the edge is a deselect: nothing is written, and any running burst ends.
- R2: A read taken at enabled edge k loads the output register at enabled edge k+1. The data is on `data_io` from that edge until the next enabled edge.
- R3: A write taken at enabled edge k stores the value that `data_io` holds at enabled edge k+2.
- R4: At an edge where `stall` is high, every other synchronous input is ignored. Every pipeline, burst and output register keeps its value, so the bus shows the same thing as before.
- R5: Lane i is `data_io[9i+8:9i]`. A write updates lane i only where `lane_mask_n[i]` was low at the edge that took that write beat. The other lanes keep their old contents.
- R6: `bus_en_n` acts without the clock. While it is high, `data_io` is high impedance.
- R7: With `burst_cont` high after an accepted access, the next beat keeps the read or write type of that access. The beat ignores `wr_n`, `addr` and the selects, but uses `lane_mask_n` of its own edge. Beat n (n=1,2,3, then wrapping) keeps the upper address bits. Its two low bits are start+n mod 4 when `order_xor` is 0, and start XOR n when `order_xor` is 1.
- R8: If `sleep_req` is sampled high at two consecutive edges k and k+1, commands from edge k+2 onward are ignored. If it is then sampled low at edges m and m+1, commands from edge m+2 are accepted again. The sleep timing counts every clock edge, including stalled ones.
- R9: Data written before sleep reads back unchanged after waking.
- R10: While asleep, new accesses and burst beats are ignored and any burst ends. The bus slot of an ignored command is high impedance.
- R11: A read taken at the edge right after a write to the same address returns that write's data in the unmasked lanes. In the masked lanes it returns the old contents.
- R12: An edge with no access (a deselect, or `burst_cont` high with no running burst) leaves `data_io` high impedance in the slot two cycles later.
- R13: While `rst_n` is low and after reset, no access is pending and `data_io` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address of a new access |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| burst_cont | input | 1 | Low: start or deselect; high: next burst beat |
| wr_n | input | 1 | Low selects write for a new access |
| lane_mask_n | input | LANES | Per-lane write enable, active low |
| stall | input | 1 | High freezes the block for that edge |
| bus_en_n | input | 1 | Asynchronous read-data drive enable, active low |
| sleep_req | input | 1 | Sleep request |
| order_xor | input | 1 | Burst order: 0 linear, 1 XOR |
| data_io | inout | LANES*LANE_W | Shared read/write data bus |

## Verification
Each command has a bus slot. That slot lies between the first and the second enabled edge after the command. The bench drives write data in that slot and samples read data or high impedance there, at the falling edge, 1 ns after it has settled its own drive.

The reference memory is updated at the second enabled edge after a write. A read's expected value is taken at the first enabled edge after the read, after that update. This gives forwarded data without any special case in the bench.

Stalled edges do not move any slot, so the same expectation is checked again. Sleep is tracked by counting the edges at which the request differs from the current state, and it affects only the edges that R8 names.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ZS_RUN   = 2'd0,
        ZS_DOZE  = 2'd1,
        ZS_SLEEP = 2'd2,
        ZS_RISE  = 2'd3
    } doze_state_e;

    localparam int unsigned BURST_SEQ_W = 2;

endpackage

// File: rtl/nbs_sleep_fsm.sv
module nbs_sleep_fsm
    import nbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep
);

    doze_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ZS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZS_RUN:   if (sleep_req)  state_d = ZS_DOZE;
            ZS_DOZE:  state_d = sleep_req ? ZS_SLEEP : ZS_RUN;
            ZS_SLEEP: if (!sleep_req) state_d = ZS_RISE;
            ZS_RISE:  state_d = sleep_req ? ZS_SLEEP : ZS_RUN;
            default:  state_d = ZS_RUN;
        endcase
    end

    always_comb begin
        asleep = (state_q == ZS_SLEEP) || (state_q == ZS_RISE);
    end

    // R8
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(sleep_req) && $past(sleep_req, 2)));

    // R8
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (!$past(sleep_req) && !$past(sleep_req, 2)));

endmodule

// File: rtl/nbs_burst_ctr.sv
module nbs_burst_ctr #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              step,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base_q;
    logic [SEQ_W-1:0]  cnt_q;
    logic [SEQ_W-1:0]  cnt_nxt;
    logic [SEQ_W-1:0]  low_bits;

    always_comb begin
        cnt_nxt  = cnt_q + 1'b1;
        low_bits = order_xor ? (base_q[SEQ_W-1:0] ^ cnt_nxt)
                             : (base_q[SEQ_W-1:0] + cnt_nxt);
        addr_o   = load ? addr_i : {base_q[ADDR_W-1:SEQ_W], low_bits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                base_q <= addr_i;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/nbs_array.sv
module nbs_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/nobubble_sram.sv
module nobubble_sram
    import nbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    burst_cont,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_mask_n,
    input  logic                    stall,
    input  logic                    bus_en_n,
    input  logic                    sleep_req,
    input  logic                    order_xor,
    inout  wire  [LANES*LANE_W-1:0] data_io
);

    localparam int unsigned DW    = LANES * LANE_W;
    localparam int unsigned SEQ_W = BURST_SEQ_W;

    logic              en;
    logic              asleep;
    logic              sel_ok;
    op_e               op_now;
    logic              load, step;
    logic              live_q, live_d;
    op_e               bop_q, bop_d;
    logic [ADDR_W-1:0] cur_addr;

    op_e               a_op_q, b_op_q;
    logic [ADDR_W-1:0] a_addr_q, b_addr_q;
    logic [LANES-1:0]  a_bw_q, b_bw_q;
    logic [DW-1:0]     out_q;
    logic              out_vld_q;

    logic [DW-1:0]     arr_rd;
    logic [DW-1:0]     rd_merged;
    logic              fwd_hit;
    logic              arr_we;

    assign en     = !stall;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    nbs_sleep_fsm u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .asleep    (asleep)
    );

    // command decode: new access, burst beat or nothing
    always_comb begin
        op_now = OP_NONE;
        load   = 1'b0;
        step   = 1'b0;
        live_d = live_q;
        bop_d  = bop_q;
        if (asleep) begin
            live_d = 1'b0;
        end else if (!burst_cont) begin
            if (sel_ok) begin
                load   = 1'b1;
                op_now = wr_n ? OP_READ : OP_WRITE;
                live_d = 1'b1;
                bop_d  = op_now;
            end else begin
                live_d = 1'b0;
            end
        end else if (live_q) begin
            step   = 1'b1;
            op_now = bop_q;
        end
    end

    nbs_burst_ctr #(
        .ADDR_W (ADDR_W),
        .SEQ_W  (SEQ_W)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load      (load),
        .step      (step),
        .order_xor (order_xor),
        .addr_i    (addr),
        .addr_o    (cur_addr)
    );

    // late write commits from stage B, data taken from the bus
    assign arr_we = en && (b_op_q == OP_WRITE);

    nbs_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .we      (arr_we),
        .lane_we (~b_bw_q),
        .waddr   (b_addr_q),
        .wdata   (data_io),
        .raddr   (a_addr_q),
        .rdata   (arr_rd)
    );

    // a read in stage A sees the write whose data is on the bus now
    assign fwd_hit = (b_op_q == OP_WRITE) && (b_addr_q == a_addr_q);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign rd_merged[g*LANE_W +: LANE_W] = (fwd_hit && !b_bw_q[g])
            ? data_io[g*LANE_W +: LANE_W]
            : arr_rd[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q    <= 1'b0;
            bop_q     <= OP_NONE;
            a_op_q    <= OP_NONE;
            a_addr_q  <= '0;
            a_bw_q    <= '1;
            b_op_q    <= OP_NONE;
            b_addr_q  <= '0;
            b_bw_q    <= '1;
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else if (en) begin
            live_q    <= live_d;
            bop_q     <= bop_d;
            a_op_q    <= op_now;
            a_addr_q  <= cur_addr;
            a_bw_q    <= lane_mask_n;
            b_op_q    <= a_op_q;
            b_addr_q  <= a_addr_q;
            b_bw_q    <= a_bw_q;
            out_q     <= rd_merged;
            out_vld_q <= (a_op_q == OP_READ);
        end
    end

    assign data_io = (out_vld_q && !bus_en_n) ? out_q : {DW{1'bz}};

    // R2
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld_q) |-> ($past(a_op_q) == OP_READ));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(a_op_q) && $stable(b_op_q) && $stable(out_q)
                   && $stable(out_vld_q) && $stable(a_addr_q)));

    // R10
    sleep_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !stall) |=> (a_op_q == OP_NONE));

endmodule

// File: tb/test_nobubble_sram.sv
module test_nobubble_sram;

    localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW, DEPTH = 1 << AW;
    localparam logic [DW-1:0] ZV = '1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic sel_a_n, sel_b, sel_c_n, burst_cont, wr_n, stall, bus_en_n, sleep_req, order_xor;
    logic [LN-1:0] lane_mask_n;
    wire  [DW-1:0] data_io;
    logic [DW-1:0] tb_dq;
    logic          tb_drv;

    assign data_io = tb_drv ? tb_dq : {DW{1'bz}};
    for (genvar g = 0; g < DW; g++) begin : g_pu
        pullup (data_io[g]);
    end

    always #4 clk = ~clk;

    nobubble_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_nobubble_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_cont(burst_cont), .wr_n(wr_n),
        .lane_mask_n(lane_mask_n), .stall(stall), .bus_en_n(bus_en_n),
        .sleep_req(sleep_req), .order_xor(order_xor), .data_io(data_io)
    );

    int n_cmp = 0, n_bad = 0;
    logic [DW-1:0] mem_m [DEPTH];
    // slot 0: command of the last enabled edge, slot 1: the one before
    int            p_op   [2];
    logic [AW-1:0] p_addr [2];
    logic [LN-1:0] p_bw   [2];
    logic [DW-1:0] p_wd   [2];
    logic [DW-1:0] p_exp  [2];
    string         p_tag  [2];
    logic          b_live = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;
    logic          asleep_m = 1'b0;
    int            zrun = 0;
    logic          stalled_last = 1'b0;
    string         cur_tag = "R13";

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: data_io=%h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic a_cont, input logic sel, input logic w_n,
                         input logic [AW-1:0] a, input logic [LN-1:0] m);
        burst_cont = a_cont; wr_n = w_n; addr = a; lane_mask_n = m;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        if (!sel) begin
            case ($urandom % 3)
                0: sel_a_n = 1'b1;
                1: sel_b = 1'b0;
                default: sel_c_n = 1'b1;
            endcase
        end
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b1, '0, '1);
    endtask

    task automatic tick();
        string tg;
        logic [63:0] r;
        tb_drv = (p_op[1] == 2);
        tb_dq  = p_wd[1];
        #1;
        tg = stalled_last ? $sformatf("R4 %s", p_tag[1]) : p_tag[1];
        if (p_op[1] == 1) begin
            if (bus_en_n) check($sformatf("R6 %s", tg), data_io, ZV);
            else          check(tg, data_io, p_exp[1]);
        end else if (p_op[1] == 0) begin
            check(tg, data_io, ZV);
        end
        @(posedge clk);
        stalled_last = stall;
        if (!stall) begin
            if (p_op[1] == 2)
                for (int l = 0; l < LN; l++)
                    if (!p_bw[1][l]) mem_m[p_addr[1]][l*LW +: LW] = p_wd[1][l*LW +: LW];
            if (p_op[0] == 1) begin
                p_exp[0] = mem_m[p_addr[0]];
                if (p_op[1] == 2 && p_addr[1] == p_addr[0]) p_tag[0] = "R11";
            end
            p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_bw[1] = p_bw[0];
            p_wd[1] = p_wd[0]; p_exp[1] = p_exp[0]; p_tag[1] = p_tag[0];
            r = {$urandom, $urandom};
            p_wd[0] = r[DW-1:0];
            p_bw[0] = lane_mask_n;
            p_op[0] = 0;
            p_tag[0] = cur_tag;
            if (asleep_m) begin
                b_live = 1'b0; p_tag[0] = "R10";
            end else if (!burst_cont) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    p_op[0] = wr_n ? 1 : 2; p_addr[0] = addr;
                    b_live = 1'b1; b_wr = !wr_n; b_base = addr; b_cnt = '0;
                end else begin
                    b_live = 1'b0; p_tag[0] = "R1 R12";
                end
            end else if (b_live) begin
                b_cnt = b_cnt + 2'd1;
                p_addr[0] = {b_base[AW-1:2], order_xor ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
                p_op[0] = b_wr ? 2 : 1;
                p_tag[0] = "R7";
            end else begin
                p_tag[0] = "R12";
            end
        end
        if (sleep_req != asleep_m) begin
            zrun++;
            if (zrun == 2) begin asleep_m = !asleep_m; zrun = 0; end
        end else zrun = 0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 2; i++) begin
            p_op[i] = 0; p_addr[i] = '0; p_bw[i] = '1; p_wd[i] = '0; p_exp[i] = '0; p_tag[i] = "R13";
        end
        tb_drv = 1'b0; tb_dq = '0;
        stall = 1'b0; bus_en_n = 1'b0; sleep_req = 1'b0; order_xor = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 in reset", data_io, ZV);
        rst_n = 1'b1;
        repeat (2) tick();

        // fill the array so every later read has a known value
        cur_tag = "R3 R5";
        for (int a = 0; a < DEPTH; a++) begin drive(1'b0, 1'b1, 1'b0, AW'(a), '0); tick(); end
        idle(); repeat (2) tick();

        // R11: read right behind a masked write to the same word
        cur_tag = "R11";
        drive(1'b0, 1'b1, 1'b0, 6'd5, 4'b1010); tick();
        drive(1'b0, 1'b1, 1'b1, 6'd5, '1); tick();
        idle(); repeat (2) tick();

        // R7: linear read burst from low bits 2, selects and address junk
        cur_tag = "R7";
        drive(1'b0, 1'b1, 1'b1, 6'd6, '1); tick();
        repeat (5) begin drive(1'b1, 1'b0, 1'b0, 6'd40, '0); tick(); end
        // R7: XOR-order write burst from 13, wr_n high on beats is ignored
        idle(); tick();
        order_xor = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 6'd13, 4'b0000); tick();
        drive(1'b1, 1'b1, 1'b1, 6'd0, 4'b0011); tick();
        drive(1'b1, 1'b1, 1'b1, 6'd0, 4'b1100); tick();
        drive(1'b1, 1'b1, 1'b1, 6'd0, 4'b0000); tick();
        idle(); tick();
        order_xor = 1'b0;
        for (int a = 12; a < 16; a++) begin drive(1'b0, 1'b1, 1'b1, AW'(a), '1); tick(); end
        idle(); repeat (2) tick();

        // R4: stall in the middle of a write/read pair with junk inputs
        cur_tag = "R4";
        drive(1'b0, 1'b1, 1'b0, 6'd20, '0); tick();
        drive(1'b0, 1'b1, 1'b1, 6'd20, '1); tick();
        stall = 1'b1;
        repeat (3) begin drive(1'b0, 1'b1, $urandom % 2, AW'($urandom), LN'($urandom)); tick(); end
        stall = 1'b0;
        idle(); repeat (3) tick();

        // R1: write with an inactive select must not land; R6: output enable
        cur_tag = "R1";
        drive(1'b0, 1'b0, 1'b0, 6'd21, '0); tick();
        idle(); tick();
        drive(1'b0, 1'b1, 1'b1, 6'd21, '1); tick();
        bus_en_n = 1'b1; tick();
        bus_en_n = 1'b0; idle(); repeat (2) tick();

        // R8 R10: writes every cycle across sleep entry and exit
        cur_tag = "R8";
        sleep_req = 1'b1;
        for (int i = 0; i < 8; i++) begin drive(1'b0, 1'b1, 1'b0, AW'(30 + i), '0); tick(); end
        sleep_req = 1'b0;
        for (int i = 0; i < 4; i++) begin drive(1'b0, 1'b1, 1'b0, AW'(38 + i), '0); tick(); end
        idle(); repeat (2) tick();
        cur_tag = "R8 R9 R10";
        for (int a = 28; a < 43; a++) begin drive(1'b0, 1'b1, 1'b1, AW'(a), '1); tick(); end
        idle(); repeat (2) tick();

        // mixed random traffic in both burst orders
        cur_tag = "R2 R3 R5";
        for (int ph = 0; ph < 2; ph++) begin
            stall = 1'b0; bus_en_n = 1'b0;
            idle(); repeat (2) tick();
            order_xor = ph[0];
            for (int i = 0; i < 2500; i++) begin
                stall    = ($urandom % 8) == 0;
                bus_en_n = ($urandom % 8) == 0;
                drive(($urandom % 10) < 3, ($urandom % 8) != 0, $urandom % 2,
                      AW'($urandom % 16), LN'($urandom));
                tick();
            end
        end
        stall = 1'b0; bus_en_n = 1'b0;
        idle(); repeat (3) tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule